// File: doc/BRIEF.md
# Column Packet Transport Chain

The block carries fixed-width hit packets along one readout column to the logic at the column's end. The column is a row of identical nodes. Each node serves one group of pixels, so it has two sources of packets. One source is its own shallow buffer, which that group writes into. The other is the packet held by the node above it. A per-node arbiter picks one of the two and places it in an output register, and that register feeds the next node down the column.

Every hop uses a valid/ready handshake. Stalls at the end of the column therefore travel upward one node at a time, until they reach the pixel groups, whose write requests are then held off. No packet is dropped or replayed on the way.

Node 0 is the far end of the column, and its upstream input is tied idle. The last node's register drives the column output. The system has no trigger, so a packet must reach the column end within the 512-cycle span of its 9-bit timestamp. Traffic per column has to be kept low enough for that latency bound to hold.

Top module: `colx_chain`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and every bit of `loc_ready` is 1.
- R2: Each node buffers at most 2 local packets. From an empty chain with `out_ready` held low, the chain accepts exactly 3×NODES packets: 2 in each buffer and 1 in each output register. After that, every `loc_ready` bit is 0.
- R3: A lone packet accepted from group i on clock edge k first shows `out_valid` high after edge k+NODES−i. That is one register hop per node, plus one cycle in the local buffer.
- R4: When a single group supplies packets without pause and `out_ready` is held high, the output delivers one packet on every cycle.
- R5: At every hop, including the column output, a packet that is valid but not accepted stays valid with unchanged data on the next cycle.
- R6: A node raises its upstream ready only when the upstream packet is valid and has been granted.
- R7: When the upstream packet and a local packet compete for a load, the winner alternates between the two sides, and the upstream side wins the first contest after reset. With every group saturated and `out_ready` high, the last node's own group gets half of the output slots.
- R8: Every accepted packet leaves the column exactly once. Packets from any one group leave in the order they were accepted, while packets from different groups may interleave.
- R9: A group's `loc_ready` falls only after a cycle in which that group presented a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | NODES | Per-group packet request, bit i for node i |
| loc_data | input | NODES×PW | Per-group packets, node i in bits [i×PW +: PW] |
| loc_ready | output | NODES | Per-group acceptance, high when that node's buffer has space |
| out_valid | output | 1 | Column output holds a packet |
| out_data | output | PW | Column output packet |
| out_ready | input | 1 | Column-end logic accepts the packet |

## Verification
The bench goes after the situations where a forwarding chain most often loses or duplicates a packet. One is a stalled output register that is overwritten or released twice, which shows up as a missing, repeated or reordered packet in a group's sequence. Another is a buffer that accepts a third entry, which would push the stall-fill count past 3×NODES or leave some `loc_ready` high. A node that ignores contention would starve its own group under saturation, and the last group's share would fall far from half. A register that skips or adds a pipeline stage shifts the lone-packet latency, and a loader that refuses to refill in the same cycle it is drained leaves gaps in a saturated stream.

// File: rtl/colx_pkg.sv
package colx_pkg;

  typedef enum logic {
    SRC_UP  = 1'b0,
    SRC_LOC = 1'b1
  } colx_src_e;

  // Upstream wins when it is alone or when it holds the turn.
  function automatic colx_src_e colx_pick(input logic up_v, input logic lo_v,
                                          input logic up_first);
    if (up_v && (!lo_v || up_first)) return SRC_UP;
    return SRC_LOC;
  endfunction

endpackage

// File: rtl/colx_fifo.sv
module colx_fifo #(
  parameter int W     = 23,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rp];

  always_comb begin
    wp_n  = do_wr ? bump(wp) : wp;
    rp_n  = do_rd ? bump(rp) : rp;
    cnt_n = cnt;
    case ({do_wr, do_rd})
      2'b10:   cnt_n = cnt + CW'(1);
      2'b01:   cnt_n = cnt - CW'(1);
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end
endmodule

// File: rtl/colx_arb.sv
module colx_arb
  import colx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      up_v,
  input  logic      lo_v,
  input  logic      take,
  output colx_src_e sel
);
  logic up_first, up_first_n;

  assign sel = colx_pick(up_v, lo_v, up_first);

  // The turn passes to the loser of each contested load.
  always_comb begin
    up_first_n = up_first;
    if (take && up_v && lo_v) up_first_n = (sel == SRC_LOC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_first <= 1'b1;
    else        up_first <= up_first_n;
  end
endmodule

// File: rtl/colx_node.sv
module colx_node
  import colx_pkg::*;
#(
  parameter int PW    = 23,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_valid,
  input  logic [PW-1:0] lo_data,
  output logic          lo_ready,
  input  logic          up_valid,
  input  logic [PW-1:0] up_data,
  output logic          up_ready,
  output logic          dn_valid,
  output logic [PW-1:0] dn_data,
  input  logic          dn_ready
);
  logic          fifo_full, fifo_empty, fifo_pop, lo_v;
  logic [PW-1:0] fifo_dout;
  logic          can_load, any_src;
  colx_src_e     sel;
  logic          ov, ov_n;
  logic [PW-1:0] od_n;

  colx_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(lo_valid), .din(lo_data), .full(fifo_full),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty)
  );

  assign lo_ready = !fifo_full;
  assign lo_v     = !fifo_empty;
  assign can_load = !ov || dn_ready;
  assign any_src  = up_valid || lo_v;

  colx_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .up_v(up_valid), .lo_v(lo_v), .take(can_load), .sel(sel)
  );

  assign up_ready = can_load && up_valid && (sel == SRC_UP);
  assign fifo_pop = can_load && lo_v && (sel == SRC_LOC);

  always_comb begin
    ov_n = ov;
    od_n = (sel == SRC_UP) ? up_data : fifo_dout;
    if (can_load) ov_n = any_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov <= 1'b0;
    else        ov <= ov_n;
  end

  always_ff @(posedge clk) begin
    if (can_load && any_src) dn_data <= od_n;
  end

  assign dn_valid = ov;
endmodule

// File: rtl/colx_chain.sv
module colx_chain #(
  parameter int NODES = 64,
  parameter int PW    = 23,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NODES-1:0]    loc_valid,
  input  logic [NODES*PW-1:0] loc_data,
  output logic [NODES-1:0]    loc_ready,
  output logic                out_valid,
  output logic [PW-1:0]       out_data,
  input  logic                out_ready
);
  logic [NODES:0]         hop_valid;
  logic [NODES:0]         hop_ready;
  logic [NODES:0][PW-1:0] hop_data;

  assign hop_valid[0]     = 1'b0;
  assign hop_data[0]      = '0;
  assign hop_ready[NODES] = out_ready;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    colx_node #(.PW(PW), .DEPTH(DEPTH)) u_node (
      .clk(clk), .rst_n(rst_n),
      .lo_valid(loc_valid[i]), .lo_data(loc_data[i*PW +: PW]), .lo_ready(loc_ready[i]),
      .up_valid(hop_valid[i]), .up_data(hop_data[i]), .up_ready(hop_ready[i]),
      .dn_valid(hop_valid[i+1]), .dn_data(hop_data[i+1]), .dn_ready(hop_ready[i+1])
    );
  end

  assign out_valid = hop_valid[NODES];
  assign out_data  = hop_data[NODES];
endmodule

// File: rtl/colx_chain_chk.sv
module colx_chain_chk #(
  parameter int NODES = 64,
  parameter int PW    = 23
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NODES-1:0]       loc_valid,
  input logic [NODES-1:0]       loc_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [NODES:0]         hop_valid,
  input logic [NODES:0]         hop_ready,
  input logic [NODES:0][PW-1:0] hop_data
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid && (&loc_ready))
        else $error("R1: column not idle during reset");
    end
  end

  for (genvar k = 1; k <= NODES; k++) begin : g_link
    p_link_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hop_valid[k] && !hop_ready[k]) |=> (hop_valid[k] && $stable(hop_data[k])))
      else $error("R5: link %0d dropped or changed a stalled packet", k);
  end

  for (genvar k = 0; k < NODES; k++) begin : g_up
    p_ready_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hop_ready[k] |-> hop_valid[k])
      else $error("R6: node %0d raised upstream ready without a packet", k);

    p_fill_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loc_ready[k]) |-> $past(loc_valid[k]))
      else $error("R9: group %0d buffer filled without a request", k);
  end

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid)
    else $error("R5: column output withdrew a stalled packet");
endmodule

bind colx_chain colx_chain_chk #(.NODES(NODES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .hop_valid(hop_valid), .hop_ready(hop_ready), .hop_data(hop_data)
);

// File: tb/tb_colx_chain.sv
module tb_colx_chain;
  localparam int N  = 4;
  localparam int PW = 23;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      loc_valid;
  logic [N*PW-1:0]   loc_data;
  logic [N-1:0]      loc_ready;
  logic              out_valid;
  logic [PW-1:0]     out_data;
  logic              out_ready;

  colx_chain #(.NODES(N), .PW(PW)) dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int rate[N], budget[N], seq[N], acc_cyc[N], src_cnt[N];
  int rdy_pct = 100, first_out = -1, accepted_total = 0;
  bit took[N];
  bit done = 0;
  logic [PW-1:0] expq[N][$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One cycle: drive at the falling edge, then record the handshakes that the next rising edge completes.
  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (took[i]) loc_valid[i] = 1'b0;
      took[i] = 0;
      if (!loc_valid[i] && budget[i] != 0 && int'($urandom % 100) < rate[i]) begin
        loc_valid[i] = 1'b1;
        loc_data[i*PW +: PW] = {4'(i), 19'(seq[i])};
      end
    end
    out_ready = int'($urandom % 100) < rdy_pct;
    #1;
    for (int i = 0; i < N; i++) begin
      if (loc_valid[i] && loc_ready[i]) begin
        expq[i].push_back(loc_data[i*PW +: PW]);
        seq[i]++;
        if (budget[i] > 0) budget[i]--;
        acc_cyc[i] = cyc;
        accepted_total++;
        took[i] = 1;
      end
    end
    if (out_valid && first_out < 0) first_out = cyc;
    if (out_valid && out_ready) begin
      int src;
      src = int'(out_data[PW-1 -: 4]);
      if (src >= N || expq[src].size() == 0) begin
        chk(0, "R8 duplicate/unknown packet", int'(out_data), -1);
      end else begin
        logic [PW-1:0] e;
        e = expq[src].pop_front();
        chk(out_data == e, "R8 order/content", int'(out_data), int'(e));
        src_cnt[src]++;
      end
    end
  endtask

  task automatic set_all(input int r, input int b);
    for (int i = 0; i < N; i++) begin rate[i] = r; budget[i] = b; end
  endtask

  task automatic drain();
    set_all(0, 0);
    rdy_pct = 100;
    repeat (120) step();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin seq[i] = 0; took[i] = 0; src_cnt[i] = 0; end
    set_all(0, 0);
    loc_valid = '0; loc_data = '0; out_ready = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(&loc_ready, "R1 loc_ready in reset", int'(loc_ready), (1 << N) - 1);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && (&loc_ready), "R1 after release", int'(out_valid), 0);

    // R3: lone packet latency; edge k to visibility after edge k+N-i is N-i+1 sampling steps.
    for (int i = 0; i < N; i++) begin
      set_all(0, 0);
      rate[i] = 100; budget[i] = 1; rdy_pct = 100; first_out = -1;
      for (int s = 0; s < 40 && first_out < 0; s++) step();
      chk(first_out - acc_cyc[i] == N - i + 1, "R3 latency steps", first_out - acc_cyc[i], N - i + 1);
      drain();
    end

    // R4: one saturated group, continuous output.
    set_all(0, 0);
    rate[N-1] = 100; budget[N-1] = -1; rdy_pct = 100;
    repeat (6) step();
    begin
      int gaps = 0;
      for (int s = 0; s < 20; s++) begin step(); if (!out_valid) gaps++; end
      chk(gaps == 0, "R4 output gaps", gaps, 0);
    end
    drain();

    // R7: all groups saturated, last group share of output slots.
    set_all(100, -1); rdy_pct = 100;
    repeat (40) step();
    for (int i = 0; i < N; i++) src_cnt[i] = 0;
    repeat (200) step();
    chk(src_cnt[N-1] >= 95 && src_cnt[N-1] <= 105, "R7 last group share", src_cnt[N-1], 100);
    chk(src_cnt[0] > 0, "R7 far group not starved", src_cnt[0], 1);
    drain();

    // R2/R5: stall the output from an empty chain.
    accepted_total = 0;
    set_all(100, -1); rdy_pct = 0;
    begin
      logic [PW-1:0] held;
      repeat (10) step();
      held = out_data;
      chk(out_valid == 1'b1, "R5 stalled output valid", int'(out_valid), 1);
      repeat (20) step();
      chk(out_valid == 1'b1 && out_data == held, "R5 stalled data held", int'(out_data), int'(held));
    end
    chk(accepted_total == 3 * N, "R2 stall capacity", accepted_total, 3 * N);
    chk(loc_ready == '0, "R2 all groups held off", int'(loc_ready), 0);
    drain();

    // R8: random traffic under random backpressure.
    set_all(50, -1); rdy_pct = 60;
    repeat (2000) step();
    drain();
    for (int i = 0; i < N; i++)
      chk(expq[i].size() == 0 && !loc_valid[i], "R8 nothing lost", expq[i].size(), 0);

    finish_run();
  end
endmodule